// File: doc/BRIEF.md
# OSD Horizontal Start Position Timer

This block marks where an on-screen display overlay begins on each video line. Running on the display oscillator clock, it resynchronises the incoming horizontal and vertical sync signals. It picks out their active edges according to a polarity select, then counts oscillator cycles from each active horizontal edge. When the count reaches a fixed base latency of 62 cycles plus four cycles per step of a programmed 7-bit position, it emits a one-cycle start pulse.

The position is written through a small register port and read back from it, but the counter works from a shadow copy. The shadow copy is refreshed only on an active vertical sync edge, so a position change never tears a frame. Each display block runs its dots from a divided copy of the oscillator. For each block a second strobe follows the common pulse by as many oscillator cycles as that block's pre-divide ratio, so the block's first dot lands one divided-clock period after the common start.

Top module: `osd_hstart_timer`

## Requirements
- R1: The position register holds 7 bits. A write stores `reg_wdata[6:0]` and `reg_rdata[6:0]` returns it from the next cycle on. `reg_rdata[7]` always reads 0 and bit 7 of a write is ignored.
- R2: Sync inputs pass a two-stage synchronizer. With `sync_neg`=1 the active edge of a sync input is its rising edge; with `sync_neg`=0 it is its falling edge. The opposite edge starts nothing.
- R3: If clock edge k is the first edge that samples an active HSYNC transition, `hstart` is high for exactly the one cycle that follows clock edge k+62+4·N. N is the position value in force (the shadow).
- R4: A written position takes effect only after the next active VSYNC edge. Until then every line keeps using the previous value.
- R5: At most one `hstart` pulse follows each active HSYNC edge. An active edge that arrives before the pulse restarts the count from that edge.
- R6: For block b, `blk_start[b]` repeats `hstart` delayed by D oscillator cycles. D is the ratio code `blk_ratio[3b+2:3b]`, with code 0 treated as 1 and codes 5 to 7 treated as 4.
- R7: During and after reset `hstart` and `blk_start` are low, the register and its shadow hold 0, and the first line after reset starts at position 0 (62 cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | OSD oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| vsync_in | input | 1 | Vertical sync, asynchronous |
| sync_neg | input | 1 | 1: active edge is rising; 0: active edge is falling |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| blk_ratio | input | NUM_BLK*3 | Per-block pre-divide ratio codes |
| hstart | output | 1 | Common horizontal start pulse |
| blk_start | output | NUM_BLK | Per-block start pulses |

## Verification
The bench builds the block with its default parameters: a 7-bit position, 4-cycle steps, a 62-cycle base, three blocks and a maximum ratio of 4. With these values both ends of the range are reachable: position 0 gives a 62-cycle line start and position 127 gives a 570-cycle one, each within a short run. Three blocks are enough to set the in-range ratios and the out-of-range codes 0 and 7 across two lines, so both clamp directions of the per-block delay are exercised. Both polarity settings are run, including inactive edges on each sync input.

// File: rtl/osd_hs_pkg.sv
package osd_hs_pkg;

  // cycles from the sampling edge of an active HSYNC transition to the strobe
  function automatic int unsigned start_latency(input int unsigned pos,
                                                input int unsigned base,
                                                input int unsigned step);
    return base + step * pos;
  endfunction

  // effective pre-divide ratio: 0 counts as 1, large codes saturate
  function automatic int unsigned clamp_ratio(input int unsigned code,
                                              input int unsigned max_ratio);
    if (code == 0) return 1;
    if (code > max_ratio) return max_ratio;
    return code;
  endfunction

endpackage

// File: rtl/osd_sync_edge.sv
module osd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  input  logic active_rise,
  output logic edge_o
);
  // pipe[0..STAGES-1] synchronizer, pipe[STAGES] previous synchronized value
  logic [STAGES:0] pipe;
  logic norm_now;
  logic norm_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], raw_in};
  end

  // polarity folded in after the synchronizer: both taps see the same select
  assign norm_now  = pipe[STAGES-1] ^ ~active_rise;
  assign norm_prev = pipe[STAGES]   ^ ~active_rise;
  assign edge_o    = norm_now & ~norm_prev;
endmodule

// File: rtl/osd_pos_regs.sv
module osd_pos_regs #(
  parameter int POS_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frame_load,
  output logic [DATA_W-1:0] rdata,
  output logic [POS_W-1:0]  shadow
);
  logic [POS_W-1:0] pos_q;
  logic             unused_hi_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pos_q <= '0;
    else if (wr_en) pos_q <= wdata[POS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          shadow <= '0;
    else if (frame_load) shadow <= pos_q;
  end

  assign unused_hi_bits = ^wdata[DATA_W-1:POS_W];
  assign rdata = {{(DATA_W-POS_W){1'b0}}, pos_q};
endmodule

// File: rtl/osd_start_counter.sv
module osd_start_counter #(
  parameter int POS_W    = 7,
  parameter int STEP_CYC = 4,
  parameter int BASE_LAT = 62,
  parameter int SYNC_LAT = 2,
  parameter int CNT_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [POS_W-1:0] position,
  output logic             strobe,
  output logic             armed_o,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic [CNT_W-1:0] target;

  assign target = CNT_W'(osd_hs_pkg::start_latency(32'(position), BASE_LAT, STEP_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (restart) begin
      // synchronizer cycles already elapsed at this point
      cnt_q   <= CNT_W'(SYNC_LAT);
      armed_q <= 1'b1;
    end else if (armed_q) begin
      if (cnt_q >= target) armed_q <= 1'b0;
      else                 cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  assign strobe  = armed_q && (cnt_q == target);
  assign armed_o = armed_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/osd_blk_delay.sv
module osd_blk_delay #(
  parameter int MAX_DIV = 4,
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe_in,
  input  logic [RATIO_W-1:0] ratio,
  output logic               strobe_out
);
  localparam int IDX_W = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

  logic [MAX_DIV-1:0] dly;
  logic [IDX_W-1:0]   sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly <= '0;
    else        dly <= {dly[MAX_DIV-2:0], strobe_in};
  end

  assign sel        = IDX_W'(osd_hs_pkg::clamp_ratio(32'(ratio), MAX_DIV) - 1);
  assign strobe_out = dly[sel];
endmodule

// File: rtl/osd_hstart_timer.sv
module osd_hstart_timer #(
  parameter int POS_W       = 7,
  parameter int DATA_W      = 8,
  parameter int STEP_CYC    = 4,
  parameter int BASE_LAT    = 62,
  parameter int NUM_BLK     = 3,
  parameter int MAX_DIV     = 4,
  parameter int RATIO_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hsync_in,
  input  logic                       vsync_in,
  input  logic                       sync_neg,
  input  logic                       reg_wr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  input  logic [NUM_BLK*RATIO_W-1:0] blk_ratio,
  output logic                       hstart,
  output logic [NUM_BLK-1:0]         blk_start
);
  localparam int MAX_LAT = BASE_LAT + STEP_CYC * ((1 << POS_W) - 1);
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  // named internal events, observed by the bound checker
  logic             hs_edge;
  logic             vs_edge;
  logic [POS_W-1:0] shadow_pos;
  logic             line_armed;
  logic [CNT_W-1:0] line_count;

  osd_sync_edge #(.STAGES(SYNC_STAGES)) u_hs_edge (
    .clk(clk), .rst_n(rst_n), .raw_in(hsync_in),
    .active_rise(sync_neg), .edge_o(hs_edge)
  );

  osd_sync_edge #(.STAGES(SYNC_STAGES)) u_vs_edge (
    .clk(clk), .rst_n(rst_n), .raw_in(vsync_in),
    .active_rise(sync_neg), .edge_o(vs_edge)
  );

  osd_pos_regs #(.POS_W(POS_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wdata(reg_wdata),
    .frame_load(vs_edge), .rdata(reg_rdata), .shadow(shadow_pos)
  );

  osd_start_counter #(
    .POS_W(POS_W), .STEP_CYC(STEP_CYC), .BASE_LAT(BASE_LAT),
    .SYNC_LAT(SYNC_STAGES), .CNT_W(CNT_W)
  ) u_count (
    .clk(clk), .rst_n(rst_n), .restart(hs_edge), .position(shadow_pos),
    .strobe(hstart), .armed_o(line_armed), .count_o(line_count)
  );

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    osd_blk_delay #(.MAX_DIV(MAX_DIV), .RATIO_W(RATIO_W)) u_dly (
      .clk(clk), .rst_n(rst_n), .strobe_in(hstart),
      .ratio(blk_ratio[b*RATIO_W +: RATIO_W]), .strobe_out(blk_start[b])
    );
  end
endmodule

// File: rtl/osd_hstart_timer_chk.sv
module osd_hstart_timer_chk #(
  parameter int POS_W       = 7,
  parameter int DATA_W      = 8,
  parameter int NUM_BLK     = 3,
  parameter int MAX_DIV     = 4,
  parameter int RATIO_W     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_wr,
  input logic [DATA_W-1:0]          reg_wdata,
  input logic [DATA_W-1:0]          reg_rdata,
  input logic                       hs_edge,
  input logic                       vs_edge,
  input logic [POS_W-1:0]           shadow_pos,
  input logic                       line_armed,
  input logic [CNT_W-1:0]           line_count,
  input logic                       hstart,
  input logic [NUM_BLK*RATIO_W-1:0] blk_ratio,
  input logic [NUM_BLK-1:0]         blk_start
);
  a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[POS_W-1:0] == $past(reg_wdata[POS_W-1:0])) &&
               (reg_rdata[DATA_W-1:POS_W] == '0));

  a_r4_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_edge |=> $stable(shadow_pos));

  a_r4_shadow_load: assert property (@(posedge clk) disable iff (!rst_n)
    vs_edge |=> shadow_pos == $past(reg_rdata[POS_W-1:0]));

  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    hstart |=> !hstart);

  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    hs_edge |=> line_armed && (line_count == CNT_W'(SYNC_STAGES)));

  a_r3_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (hstart && !hs_edge) |=> !line_armed);

  a_r7_quiet_reset: assert property (@(posedge clk)
    !rst_n |-> !hstart && (blk_start == '0));

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    int unsigned eff;
    assign eff = osd_hs_pkg::clamp_ratio(32'(blk_ratio[b*RATIO_W +: RATIO_W]), MAX_DIV);
    for (genvar d = 1; d <= MAX_DIV; d++) begin : g_d
      a_r6_blk_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_start[b] && eff == d) |-> $past(hstart, d));
      a_r6_blk_fires: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hstart, d) && eff == d) |-> blk_start[b]);
    end
  end
endmodule

bind osd_hstart_timer osd_hstart_timer_chk #(
  .POS_W(POS_W), .DATA_W(DATA_W), .NUM_BLK(NUM_BLK), .MAX_DIV(MAX_DIV),
  .RATIO_W(RATIO_W), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .hs_edge(hs_edge), .vs_edge(vs_edge),
  .shadow_pos(shadow_pos), .line_armed(line_armed), .line_count(line_count),
  .hstart(hstart), .blk_ratio(blk_ratio), .blk_start(blk_start)
);

// File: tb/osd_hstart_timer_tb.sv
`timescale 1ns/1ps
module osd_hstart_timer_tb;
  localparam int NB = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hsync_in = 1'b0;
  logic          vsync_in = 1'b0;
  logic          sync_neg = 1'b1;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [NB*3-1:0] blk_ratio = '0;
  logic          hstart;
  logic [NB-1:0] blk_start;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  osd_hstart_timer u_dut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .sync_neg(sync_neg), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .blk_ratio(blk_ratio), .hstart(hstart),
    .blk_start(blk_start)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int exp_delay(input int code);
    if (code < 1) return 1;
    else if (code > 4) return 4;
    else return code;
  endfunction

  task automatic write_pos(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  // inactive level first, then the active transition at a falling clock edge
  task automatic hs_fire();
    @(negedge clk); hsync_in = sync_neg ? 1'b0 : 1'b1;
    repeat (4) @(negedge clk);
    hsync_in = sync_neg ? 1'b1 : 1'b0;
  endtask

  task automatic vs_fire();
    @(negedge clk); vsync_in = sync_neg ? 1'b0 : 1'b1;
    repeat (4) @(negedge clk);
    vsync_in = sync_neg ? 1'b1 : 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // called right after the active transition; counts falling edges from there
  task automatic measure_line(input int n_val, input string tag);
    int lat = 62 + 4 * n_val;
    int first = -1;
    int hits = 0;
    int bfirst[NB];
    int bhits[NB];
    for (int b = 0; b < NB; b++) begin bfirst[b] = -1; bhits[b] = 0; end
    for (int i = 1; i <= lat + 12; i++) begin
      @(negedge clk);
      if (hstart) begin hits++; if (first < 0) first = i; end
      for (int b = 0; b < NB; b++)
        if (blk_start[b]) begin bhits[b]++; if (bfirst[b] < 0) bfirst[b] = i; end
    end
    chk(first == lat + 1, {"R3 start position ", tag}, first, lat + 1);
    chk(hits == 1, {"R5 pulses per line ", tag}, hits, 1);
    for (int b = 0; b < NB; b++) begin
      int e = exp_delay(int'(blk_ratio[b*3 +: 3]));
      chk(bfirst[b] == lat + 1 + e, {"R6 block start ", tag}, bfirst[b], lat + 1 + e);
      chk(bhits[b] == 1, {"R6 block pulses ", tag}, bhits[b], 1);
    end
  endtask

  task automatic expect_silence(input int cycles, input string tag);
    int hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (hstart || blk_start != '0) hits++;
    end
    chk(hits == 0, {"R2 no strobe ", tag}, hits, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(hstart == 1'b0, "R7 hstart in reset", int'(hstart), 0);
    chk(blk_start == '0, "R7 blk_start in reset", int'(blk_start), 0);
    chk(reg_rdata == 8'h00, "R7 register in reset", int'(reg_rdata), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(reg_rdata == 8'h00, "R7 register after reset", int'(reg_rdata), 0);
  endtask

  task automatic t_first_line();
    blk_ratio = {3'd3, 3'd2, 3'd1};
    hs_fire();
    measure_line(0, "R7 first line");
  endtask

  task automatic t_register();
    write_pos(8'hFF);
    @(negedge clk);
    chk(reg_rdata == 8'h7F, "R1 bit7 dropped", int'(reg_rdata), 8'h7F);
    write_pos(8'h85);
    @(negedge clk);
    chk(reg_rdata == 8'h05, "R1 readback", int'(reg_rdata), 8'h05);
  endtask

  task automatic t_deferred();
    write_pos(8'd10);
    hs_fire();
    measure_line(0, "R4 before vsync");
    vs_fire();
    hs_fire();
    measure_line(10, "R4 after vsync");
  endtask

  task automatic t_extremes();
    write_pos(8'd127);
    vs_fire();
    blk_ratio = {3'd4, 3'd7, 3'd0};
    hs_fire();
    measure_line(127, "R3 max position R6 clamps");
    write_pos(8'd1);
    vs_fire();
    blk_ratio = {3'd1, 3'd3, 3'd2};
    hs_fire();
    measure_line(1, "R3 position 1");
  endtask

  task automatic t_restart();
    hs_fire();
    repeat (30) @(negedge clk);
    hs_fire();
    measure_line(1, "R5 restart");
  endtask

  task automatic t_positive();
    @(negedge clk);
    sync_neg = 1'b0; hsync_in = 1'b1; vsync_in = 1'b1;
    repeat (700) @(negedge clk);
    write_pos(8'd20);
    vs_fire();
    hs_fire();
    measure_line(20, "R2 falling edge active");
    @(negedge clk); hsync_in = 1'b1;
    expect_silence(200, "on rising hsync");
    write_pos(8'd50);
    @(negedge clk); vsync_in = 1'b1;
    repeat (8) @(negedge clk);
    hs_fire();
    measure_line(20, "R4 R2 rising vsync ignored");
  endtask

  initial begin
    t_reset();
    t_first_line();
    t_register();
    t_deferred();
    t_extremes();
    t_restart();
    t_positive();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule